// File: doc/BRIEF.md
# In-Memory Row Copy Command Sequencer

This block sits in a memory controller, between the request path and the DRAM command bus. It takes one bulk request at a time and turns it into a timed stream of ACTIVATE, PRECHARGE, column-write and bank-to-bank transfer commands. The stream copies or initializes whole rows inside the memory device, so no row data crosses the external data channel. A request is either a copy, which names a source and a destination row, or an initialization. An initialization names a first destination row, a row count and a fill value. Every row is addressed by bank, subarray and row-within-subarray.

The block looks at where the rows sit and chooses how to move the data. When both rows are in one subarray, it uses two activations back to back, so the row buffer carries the data from the first row into the second. When the rows are in different banks, it opens both and streams the row column by column over the internal bus. When the rows are in different subarrays of one bank, it does that streamed transfer twice, through a scratch row in a neighbouring bank. Zeroing copies from a reserved all-zero row in the target subarray. Any other fill value is first written into one row, and that row is then copied to the other rows. The timing gaps come from parameters. The number of column beats per row is a configuration input.

Top module: `rowcopy_seq`

## Requirements
- R1: A copy whose source and destination share bank and subarray issues exactly PRECHARGE(bank), ACTIVATE(source), ACTIVATE(destination), PRECHARGE(bank). The gaps between these commands are at least T_RP, T_RAS and T_RAS.
- R2: That same-subarray sequence issues no column command (kind 2 or 3), so the whole row is always moved.
- R3: A copy between different banks issues PRECHARGE(source bank), PRECHARGE(destination bank), ACTIVATE(source) after T_RP, and ACTIVATE(destination) after T_RCD. It then issues cfg_cols transfer beats with columns 0 upward, each naming the source bank in cmd_bank and the destination bank in cmd_bank2, spaced at least T_CCD apart, the first at least T_RCD after the last ACTIVATE. The sequence ends with PRECHARGE(source) at least T_RAS after the last beat, then PRECHARGE(destination).
- R4: A copy between subarrays of one bank runs the R3 sequence twice. The first run goes from the source to the scratch row and the second from the scratch row to the destination. The scratch row is in the destination bank with bit 0 inverted, subarray 0, row TEMP_ROW.
- R5: An initialization (req_op=1) with value 0 runs one R1 sequence per destination row, each with row 0 of the destination subarray as its source.
- R6: An initialization with a nonzero value first fills the first destination row. The fill is PRECHARGE, ACTIVATE, then cfg_cols column writes (kind 2) carrying the value, then PRECHARGE. It then runs an R1 sequence from that row to each following row.
- R7: A row count of 0 behaves as 1, and a cfg_cols of 0 behaves as 1.
- R8: busy rises the cycle after a request is accepted. While busy, new requests are ignored and do not change the command stream.
- R9: done is a one-cycle pulse in the cycle busy falls, at least T_RP cycles after the final PRECHARGE.
- R10: A request whose destination is row 0, or whose initialization range runs past the last row of the subarray, gives a one-cycle err pulse. It issues no command and leaves busy low.
- R11: After reset, busy, done, err and cmd_valid are low.
- R12: No bank receives more than two ACTIVATEs without a PRECHARGE in between, and every bank is precharged when done is raised.

Command kinds on cmd_kind: 0 ACTIVATE, 1 PRECHARGE, 2 column write, 3 bank-to-bank transfer. Operation codes on req_op: 0 copy, 1 initialization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_op | input | 1 | 0 copy, 1 initialization |
| req_src_bank | input | 2 | Source bank |
| req_src_sub | input | 2 | Source subarray |
| req_src_row | input | 4 | Source row in subarray |
| req_dst_bank | input | 2 | Destination bank |
| req_dst_sub | input | 2 | Destination subarray |
| req_dst_row | input | 4 | First destination row |
| req_count | input | 4 | Initialization row count |
| req_value | input | 8 | Initialization fill value |
| cfg_cols | input | 4 | Column beats per row |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished pulse |
| err | output | 1 | Request rejected pulse |
| cmd_valid | output | 1 | Command present this cycle |
| cmd_kind | output | 2 | Command kind |
| cmd_bank | output | 2 | Target bank (source bank for transfers) |
| cmd_sub | output | 2 | Subarray for ACTIVATE |
| cmd_row | output | 4 | Row for ACTIVATE |
| cmd_col | output | 4 | Column for write or transfer |
| cmd_bank2 | output | 2 | Destination bank for transfers |
| cmd_data | output | 8 | Data for column write |

## Verification
Some rules are checked by assertions on every cycle. No bank is activated three times without a precharge. All banks are closed when done rises. busy falls only together with done. err never appears while busy. The latched request stays fixed during a sequence. The double-activate path is only ever given rows in one subarray. Beat columns stay below the configured count. The scoreboard scenarios cover the rest: the exact command order and minimum gaps for each copy mode, the scratch-row address, the reserved-zero source, the fill data, the zero-count and zero-column cases, and the rejection cases.

// File: rtl/rowcopy_pkg.sv
package rowcopy_pkg;

    localparam int BANK_W = 2;
    localparam int SUB_W  = 2;
    localparam int ROW_W  = 4;
    localparam int COL_W  = 4;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 4;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [SUB_W-1:0]  sub;
        logic [ROW_W-1:0]  row;
    } row_addr_t;

    typedef enum logic [1:0] {
        CMD_ACT  = 2'd0,
        CMD_PRE  = 2'd1,
        CMD_WR   = 2'd2,
        CMD_XFER = 2'd3
    } cmd_kind_t;

    typedef enum logic [2:0] {
        PLAN_DUAL_ACT,
        PLAN_STREAM,
        PLAN_STREAM_TWICE,
        PLAN_ZERO,
        PLAN_FILL
    } plan_mode_t;

    typedef enum logic [1:0] {
        OP_DUAL_ACT,
        OP_STREAM,
        OP_FILL
    } op_kind_t;

    typedef struct packed {
        op_kind_t  kind;
        row_addr_t src;
        row_addr_t dst;
    } op_desc_t;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/rc_classify.sv
module rc_classify
    import rowcopy_pkg::*;
(
    input  logic              is_init,
    input  row_addr_t         src,
    input  row_addr_t         dst,
    input  logic [CNT_W-1:0]  count,
    input  logic [DATA_W-1:0] value,
    output plan_mode_t        mode,
    output logic [CNT_W-1:0]  n_ops,
    output logic              bad
);
    localparam int SPAN_W = ROW_W + CNT_W + 1;
    localparam logic [SPAN_W-1:0] LAST_ROW = SPAN_W'((1 << ROW_W) - 1);

    logic [CNT_W-1:0]  cnt_eff;
    logic [SPAN_W-1:0] span_end;

    always_comb begin
        cnt_eff  = (count == '0) ? CNT_W'(1) : count;
        span_end = SPAN_W'(dst.row) + SPAN_W'(cnt_eff) - SPAN_W'(1);
        if (is_init) begin
            mode  = (value == '0) ? PLAN_ZERO : PLAN_FILL;
            n_ops = cnt_eff;
            bad   = (dst.row == '0) || (span_end > LAST_ROW);
        end else begin
            bad = (dst.row == '0);
            if (src.bank != dst.bank) begin
                mode  = PLAN_STREAM;
                n_ops = CNT_W'(1);
            end else if (src.sub != dst.sub) begin
                mode  = PLAN_STREAM_TWICE;
                n_ops = CNT_W'(2);
            end else begin
                mode  = PLAN_DUAL_ACT;
                n_ops = CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/rc_gap_timer.sv
module rc_gap_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/rc_op_engine.sv
module rc_op_engine
    import rowcopy_pkg::*;
#(
    parameter int T_RP  = 3,
    parameter int T_RCD = 3,
    parameter int T_RAS = 6,
    parameter int T_CCD = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  op_desc_t          op,
    input  logic [COL_W-1:0]  cols,
    input  logic [DATA_W-1:0] wdata,
    output logic              cmd_valid,
    output cmd_kind_t         cmd_kind,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [SUB_W-1:0]  cmd_sub,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic [BANK_W-1:0] cmd_bank2,
    output logic [DATA_W-1:0] cmd_data,
    output logic              op_done
);
    localparam int TMAX = max4(T_RP, T_RCD, T_RAS, T_CCD);
    localparam int TW   = $clog2(TMAX + 1);

    typedef enum logic [3:0] {
        E_IDLE, E_PRE_S, E_PRE_D, E_ACT_S, E_ACT_D,
        E_BEAT, E_PRE_ES, E_PRE_ED, E_END
    } eng_state_t;

    eng_state_t        state, nxt;
    op_desc_t          op_q;
    logic [COL_W-1:0]  cols_q;
    logic [DATA_W-1:0] wdata_q;
    logic [COL_W-1:0]  col;
    logic              expired, issue, last_beat;
    int                dly;
    cmd_kind_t         c_kind;
    logic [BANK_W-1:0] c_bank;
    logic [SUB_W-1:0]  c_sub;
    logic [ROW_W-1:0]  c_row;
    logic [DATA_W-1:0] c_data;

    rc_gap_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (issue),
        .load_val (TW'(dly - 1)),
        .expired  (expired)
    );

    always_comb begin
        nxt       = state;
        dly       = 1;
        c_kind    = CMD_PRE;
        c_bank    = op_q.dst.bank;
        c_sub     = '0;
        c_row     = '0;
        c_data    = '0;
        last_beat = ({1'b0, col} + (COL_W+1)'(1)) >= {1'b0, cols_q};
        issue     = expired && (state != E_IDLE) && (state != E_END);
        case (state)
            E_PRE_S: begin
                c_bank = op_q.src.bank;
                nxt    = E_PRE_D;
            end
            E_PRE_D: begin
                dly = T_RP;
                nxt = (op_q.kind == OP_FILL) ? E_ACT_D : E_ACT_S;
            end
            E_ACT_S: begin
                c_kind = CMD_ACT;
                c_bank = op_q.src.bank;
                c_sub  = op_q.src.sub;
                c_row  = op_q.src.row;
                dly    = (op_q.kind == OP_DUAL_ACT) ? T_RAS : T_RCD;
                nxt    = E_ACT_D;
            end
            E_ACT_D: begin
                c_kind = CMD_ACT;
                c_sub  = op_q.dst.sub;
                c_row  = op_q.dst.row;
                dly    = (op_q.kind == OP_DUAL_ACT) ? T_RAS : T_RCD;
                nxt    = (op_q.kind == OP_DUAL_ACT) ? E_PRE_ED : E_BEAT;
            end
            E_BEAT: begin
                if (op_q.kind == OP_FILL) begin
                    c_kind = CMD_WR;
                    c_data = wdata_q;
                end else begin
                    c_kind = CMD_XFER;
                    c_bank = op_q.src.bank;
                end
                dly = last_beat ? T_RAS : T_CCD;
                nxt = !last_beat ? E_BEAT :
                      (op_q.kind == OP_STREAM) ? E_PRE_ES : E_PRE_ED;
            end
            E_PRE_ES: begin
                c_bank = op_q.src.bank;
                nxt    = E_PRE_ED;
            end
            E_PRE_ED: begin
                dly = T_RP;
                nxt = E_END;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= E_IDLE;
            op_q      <= '0;
            cols_q    <= '0;
            wdata_q   <= '0;
            col       <= '0;
            cmd_valid <= 1'b0;
            cmd_kind  <= CMD_ACT;
            cmd_bank  <= '0;
            cmd_sub   <= '0;
            cmd_row   <= '0;
            cmd_col   <= '0;
            cmd_bank2 <= '0;
            cmd_data  <= '0;
            op_done   <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            op_done   <= 1'b0;
            if (state == E_IDLE) begin
                if (start) begin
                    op_q    <= op;
                    cols_q  <= cols;
                    wdata_q <= wdata;
                    col     <= '0;
                    state   <= (op.kind == OP_STREAM) ? E_PRE_S : E_PRE_D;
                end
            end else if (state == E_END) begin
                if (expired) begin
                    op_done <= 1'b1;
                    state   <= E_IDLE;
                end
            end else if (issue) begin
                cmd_valid <= 1'b1;
                cmd_kind  <= c_kind;
                cmd_bank  <= c_bank;
                cmd_sub   <= c_sub;
                cmd_row   <= c_row;
                cmd_col   <= (state == E_BEAT) ? col : '0;
                cmd_bank2 <= (state == E_BEAT) ? op_q.dst.bank : '0;
                cmd_data  <= c_data;
                if (state == E_BEAT) col <= col + COL_W'(1);
                state <= nxt;
            end
        end
    end

    AST_DUAL_ACT_ONE_SUBARRAY: assert property (@(posedge clk) disable iff (rst)
        (issue && state == E_ACT_D && op_q.kind == OP_DUAL_ACT) |->
        (op_q.src.bank == op_q.dst.bank && op_q.src.sub == op_q.dst.sub)); // R1

    AST_BEAT_COL_RANGE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_kind == CMD_WR || cmd_kind == CMD_XFER)) |->
        (cmd_col == '0 || cmd_col < cols_q)); // R3

    AST_DUAL_ACT_NO_COLUMN: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op_q.kind == OP_DUAL_ACT) |->
        (cmd_kind == CMD_ACT || cmd_kind == CMD_PRE)); // R2
endmodule

// File: rtl/rowcopy_seq.sv
module rowcopy_seq
    import rowcopy_pkg::*;
#(
    parameter int T_RP     = 3,
    parameter int T_RCD    = 3,
    parameter int T_RAS    = 6,
    parameter int T_CCD    = 2,
    parameter int TEMP_ROW = (1 << ROW_W) - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_op,
    input  logic [BANK_W-1:0] req_src_bank,
    input  logic [SUB_W-1:0]  req_src_sub,
    input  logic [ROW_W-1:0]  req_src_row,
    input  logic [BANK_W-1:0] req_dst_bank,
    input  logic [SUB_W-1:0]  req_dst_sub,
    input  logic [ROW_W-1:0]  req_dst_row,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [DATA_W-1:0] req_value,
    input  logic [COL_W-1:0]  cfg_cols,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              cmd_valid,
    output logic [1:0]        cmd_kind,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [SUB_W-1:0]  cmd_sub,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic [BANK_W-1:0] cmd_bank2,
    output logic [DATA_W-1:0] cmd_data
);
    localparam int NBANK = 1 << BANK_W;
    localparam logic [ROW_W-1:0] SCRATCH_ROW = ROW_W'(TEMP_ROW);

    row_addr_t         in_src, in_dst;
    plan_mode_t        in_mode, mode_q;
    logic [CNT_W-1:0]  in_nops, nops_q, op_idx;
    logic              in_bad, accept, reject, launch, op_done;
    row_addr_t         src_q, dst_q, scratch;
    logic [COL_W-1:0]  cols_q;
    logic [DATA_W-1:0] value_q;
    op_desc_t          cur_op;
    cmd_kind_t         eng_kind;

    assign in_src = '{bank: req_src_bank, sub: req_src_sub, row: req_src_row};
    assign in_dst = '{bank: req_dst_bank, sub: req_dst_sub, row: req_dst_row};

    rc_classify u_classify (
        .is_init (req_op),
        .src     (in_src),
        .dst     (in_dst),
        .count   (req_count),
        .value   (req_value),
        .mode    (in_mode),
        .n_ops   (in_nops),
        .bad     (in_bad)
    );

    assign accept = req_valid && !busy && !in_bad;
    assign reject = req_valid && !busy && in_bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            err     <= 1'b0;
            launch  <= 1'b0;
            mode_q  <= PLAN_DUAL_ACT;
            nops_q  <= '0;
            op_idx  <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            cols_q  <= '0;
            value_q <= '0;
        end else begin
            done   <= 1'b0;
            err    <= 1'b0;
            launch <= 1'b0;
            if (accept) begin
                busy    <= 1'b1;
                launch  <= 1'b1;
                mode_q  <= in_mode;
                nops_q  <= in_nops;
                op_idx  <= '0;
                src_q   <= in_src;
                dst_q   <= in_dst;
                cols_q  <= cfg_cols;
                value_q <= req_value;
            end else if (reject) begin
                err <= 1'b1;
            end
            if (busy && op_done) begin
                if (op_idx == nops_q - CNT_W'(1)) begin
                    done <= 1'b1;
                    busy <= 1'b0;
                end else begin
                    op_idx <= op_idx + CNT_W'(1);
                    launch <= 1'b1;
                end
            end
        end
    end

    assign scratch = '{bank: dst_q.bank ^ BANK_W'(1), sub: '0, row: SCRATCH_ROW};

    always_comb begin
        cur_op = '0;
        case (mode_q)
            PLAN_DUAL_ACT: begin
                cur_op.kind = OP_DUAL_ACT;
                cur_op.src  = src_q;
                cur_op.dst  = dst_q;
            end
            PLAN_STREAM: begin
                cur_op.kind = OP_STREAM;
                cur_op.src  = src_q;
                cur_op.dst  = dst_q;
            end
            PLAN_STREAM_TWICE: begin
                cur_op.kind = OP_STREAM;
                cur_op.src  = (op_idx == '0) ? src_q : scratch;
                cur_op.dst  = (op_idx == '0) ? scratch : dst_q;
            end
            PLAN_ZERO: begin
                cur_op.kind     = OP_DUAL_ACT;
                cur_op.src      = '{bank: dst_q.bank, sub: dst_q.sub, row: '0};
                cur_op.dst      = dst_q;
                cur_op.dst.row  = dst_q.row + ROW_W'(op_idx);
            end
            default: begin
                cur_op.kind     = (op_idx == '0) ? OP_FILL : OP_DUAL_ACT;
                cur_op.src      = dst_q;
                cur_op.dst      = dst_q;
                cur_op.dst.row  = dst_q.row + ROW_W'(op_idx);
            end
        endcase
    end

    rc_op_engine #(
        .T_RP  (T_RP),
        .T_RCD (T_RCD),
        .T_RAS (T_RAS),
        .T_CCD (T_CCD)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (launch),
        .op        (cur_op),
        .cols      (cols_q),
        .wdata     (value_q),
        .cmd_valid (cmd_valid),
        .cmd_kind  (eng_kind),
        .cmd_bank  (cmd_bank),
        .cmd_sub   (cmd_sub),
        .cmd_row   (cmd_row),
        .cmd_col   (cmd_col),
        .cmd_bank2 (cmd_bank2),
        .cmd_data  (cmd_data),
        .op_done   (op_done)
    );

    assign cmd_kind = eng_kind;

    logic [1:0]       act_cnt [NBANK];
    logic [NBANK-1:0] bank_open;

    for (genvar g = 0; g < NBANK; g++) begin : g_bank_track
        always_ff @(posedge clk) begin
            if (rst) begin
                act_cnt[g] <= '0;
            end else if (cmd_valid && cmd_bank == BANK_W'(g)) begin
                if (eng_kind == CMD_PRE)
                    act_cnt[g] <= '0;
                else if (eng_kind == CMD_ACT && act_cnt[g] != 2'd3)
                    act_cnt[g] <= act_cnt[g] + 2'd1;
            end
        end
        assign bank_open[g] = (act_cnt[g] != '0);
    end

    AST_ACT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && eng_kind == CMD_ACT) |-> (act_cnt[cmd_bank] < 2'd2)); // R12

    AST_DONE_ALL_CLOSED: assert property (@(posedge clk) disable iff (rst)
        done |-> (bank_open == '0)); // R12

    AST_BUSY_FALL_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R9

    AST_ERR_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        err |-> !busy); // R10

    AST_REQ_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && busy) |-> ($stable(dst_q) && $stable(src_q) && $stable(mode_q))); // R8
endmodule

// File: tb/rowcopy_seq_test.sv
module rowcopy_seq_test;
    localparam int T_RP = 3, T_RCD = 3, T_RAS = 6, T_CCD = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0, req_op = 1'b0;
    logic [1:0] req_src_bank = '0, req_src_sub = '0, req_dst_bank = '0, req_dst_sub = '0;
    logic [3:0] req_src_row = '0, req_dst_row = '0, req_count = '0, cfg_cols = '0;
    logic [7:0] req_value = '0;
    logic       busy, done, err, cmd_valid;
    logic [1:0] cmd_kind, cmd_bank, cmd_sub, cmd_bank2;
    logic [3:0] cmd_row, cmd_col;
    logic [7:0] cmd_data;

    rowcopy_seq #(.T_RP(T_RP), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_CCD(T_CCD)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_src_bank(req_src_bank), .req_src_sub(req_src_sub), .req_src_row(req_src_row),
        .req_dst_bank(req_dst_bank), .req_dst_sub(req_dst_sub), .req_dst_row(req_dst_row),
        .req_count(req_count), .req_value(req_value), .cfg_cols(cfg_cols),
        .busy(busy), .done(done), .err(err), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_bank(cmd_bank), .cmd_sub(cmd_sub), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .cmd_bank2(cmd_bank2), .cmd_data(cmd_data)
    );

    always #4 clk = ~clk;

    typedef struct {
        int    kind, bank, sub, row, col, bank2, data, gap;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0, errors = 0, cyc = 0, last_cmd = 0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic void push(input int k, input int b, input int s, input int r, input int c,
                                 input int b2, input int d, input int g, input string req);
        exp_t e;
        e.kind = k; e.bank = b; e.sub = s; e.row = r; e.col = c;
        e.bank2 = b2; e.data = d; e.gap = g; e.req = req;
        exp_q.push_back(e);
    endfunction

    function automatic void exp_dual(input int b, input int s, input int sr, input int dr, input int g0, input string req);
        push(1, b, 0, 0, 0, 0, 0, g0, req);
        push(0, b, s, sr, 0, 0, 0, T_RP, req);
        push(0, b, s, dr, 0, 0, 0, T_RAS, req);
        push(1, b, 0, 0, 0, 0, 0, T_RAS, req);
    endfunction

    function automatic void exp_stream(input int sb, input int ss, input int sr, input int db, input int ds,
                                       input int dr, input int cols, input int g0, input string req);
        int n;
        n = (cols == 0) ? 1 : cols;
        push(1, sb, 0, 0, 0, 0, 0, g0, req);
        push(1, db, 0, 0, 0, 0, 0, 1, req);
        push(0, sb, ss, sr, 0, 0, 0, T_RP, req);
        push(0, db, ds, dr, 0, 0, 0, T_RCD, req);
        for (int c = 0; c < n; c++)
            push(3, sb, 0, 0, c, db, 0, (c == 0) ? T_RCD : T_CCD, req);
        push(1, sb, 0, 0, 0, 0, 0, T_RAS, req);
        push(1, db, 0, 0, 0, 0, 0, 1, req);
    endfunction

    function automatic void exp_fill(input int b, input int s, input int r, input int v, input int cols, input string req);
        int n;
        n = (cols == 0) ? 1 : cols;
        push(1, b, 0, 0, 0, 0, 0, 0, req);
        push(0, b, s, r, 0, 0, 0, T_RP, req);
        for (int c = 0; c < n; c++)
            push(2, b, 0, 0, c, 0, v, (c == 0) ? T_RCD : T_CCD, req);
        push(1, b, 0, 0, 0, 0, 0, T_RAS, req);
    endfunction

    // Monitor: pops expected commands and compares
    always @(negedge clk) begin
        if (!rst && cmd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8/R10", "unexpected command kind", int'(cmd_kind), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(int'(cmd_kind) == e.kind, e.req, "cmd_kind", int'(cmd_kind), e.kind);
                check(int'(cmd_bank) == e.bank, e.req, "cmd_bank", int'(cmd_bank), e.bank);
                if (e.kind == 0) begin
                    check(int'(cmd_sub) == e.sub, e.req, "cmd_sub", int'(cmd_sub), e.sub);
                    check(int'(cmd_row) == e.row, e.req, "cmd_row", int'(cmd_row), e.row);
                end
                if (e.kind >= 2)
                    check(int'(cmd_col) == e.col, e.req, "cmd_col", int'(cmd_col), e.col);
                if (e.kind == 3)
                    check(int'(cmd_bank2) == e.bank2, e.req, "cmd_bank2", int'(cmd_bank2), e.bank2);
                if (e.kind == 2)
                    check(int'(cmd_data) == e.data, e.req, "cmd_data", int'(cmd_data), e.data);
                if (e.gap > 0)
                    check(cyc - last_cmd >= e.gap, e.req, "command gap", cyc - last_cmd, e.gap);
            end
            last_cmd = cyc;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic send(input bit op, input int sb, input int ss, input int sr, input int db,
                        input int ds, input int dr, input int cnt, input int val, input int cols);
        @(negedge clk);
        req_valid = 1'b1; req_op = op;
        req_src_bank = 2'(sb); req_src_sub = 2'(ss); req_src_row = 4'(sr);
        req_dst_bank = 2'(db); req_dst_sub = 2'(ds); req_dst_row = 4'(dr);
        req_count = 4'(cnt); req_value = 8'(val); cfg_cols = 4'(cols);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_req(input string req);
        int waited = 0;
        while (!done && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        check(done == 1'b1, "R9", {"done seen for ", req}, int'(done), 1);
        check(busy == 1'b0, "R9", "busy falls with done", int'(busy), 0);
        check(cyc - last_cmd >= T_RP, "R9", "done after final precharge", cyc - last_cmd, T_RP);
        check(exp_q.size() == 0, req, "expected commands left", exp_q.size(), 0);
        @(negedge clk);
        check(done == 1'b0, "R9", "done is one cycle", int'(done), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !err && !cmd_valid, "R11", "outputs after reset",
              int'({busy, done, err, cmd_valid}), 0);
        rst = 1'b0;
        @(negedge clk);

        // R1 R2: same subarray copy
        exp_dual(1, 2, 5, 9, 0, "R1");
        send(1'b0, 1, 2, 5, 1, 2, 9, 0, 0, 4);
        check(busy == 1'b1, "R8", "busy after accept", int'(busy), 1);
        finish_req("R1");

        // R3: bank to bank
        exp_stream(0, 1, 3, 2, 3, 7, 4, 0, "R3");
        send(1'b0, 0, 1, 3, 2, 3, 7, 0, 0, 4);
        finish_req("R3");

        // R4: subarray to subarray through scratch row
        exp_stream(3, 0, 4, 2, 0, 15, 2, 0, "R4");
        exp_stream(2, 0, 15, 3, 2, 6, 2, T_RP, "R4");
        send(1'b0, 3, 0, 4, 3, 2, 6, 0, 0, 2);
        finish_req("R4");

        // R5: zero init up to the last row (boundary accepted)
        for (int i = 0; i < 3; i++)
            exp_dual(2, 1, 0, 13 + i, (i == 0) ? 0 : T_RP, "R5");
        send(1'b1, 0, 0, 0, 2, 1, 13, 3, 0, 4);
        check(err == 1'b0, "R10", "range ending on last row accepted", int'(err), 0);
        finish_req("R5");

        // R6: nonzero fill then copies
        exp_fill(0, 3, 10, 8'hA5, 3, "R6");
        exp_dual(0, 3, 10, 11, T_RP, "R6");
        exp_dual(0, 3, 10, 12, T_RP, "R6");
        send(1'b1, 0, 0, 0, 0, 3, 10, 3, 8'hA5, 3);
        finish_req("R6");

        // R7: zero count and zero columns
        exp_fill(1, 0, 7, 8'h3C, 0, "R7");
        send(1'b1, 0, 0, 0, 1, 0, 7, 0, 8'h3C, 0);
        finish_req("R7");
        exp_stream(1, 1, 2, 0, 1, 4, 0, 0, "R7");
        send(1'b0, 1, 1, 2, 0, 1, 4, 0, 0, 0);
        finish_req("R7");

        // R10: reserved row as destination, range past end
        send(1'b0, 1, 1, 5, 1, 1, 0, 0, 0, 4);
        check(err == 1'b1, "R10", "err for row 0 destination", int'(err), 1);
        check(busy == 1'b0, "R10", "busy stays low on reject", int'(busy), 0);
        @(negedge clk);
        check(err == 1'b0, "R10", "err is one cycle", int'(err), 0);
        send(1'b1, 0, 0, 0, 2, 2, 14, 3, 0, 4);
        check(err == 1'b1, "R10", "err for range past last row", int'(err), 1);
        repeat (20) @(negedge clk);
        check(cyc - last_cmd >= 20, "R10", "no command after reject", cyc - last_cmd, 20);

        // R8: request while busy is ignored
        exp_dual(3, 1, 2, 6, 0, "R8");
        send(1'b0, 3, 1, 2, 3, 1, 6, 0, 0, 4);
        repeat (2) @(negedge clk);
        send(1'b0, 0, 0, 1, 2, 0, 3, 0, 0, 4);
        check(err == 1'b0 && busy == 1'b1, "R8", "busy request ignored",
              int'({err, busy}), 1);
        finish_req("R8");
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R8", "no late commands", exp_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule